// File: doc/BRIEF.md
# Raster Timing Generator

This block paces one display pipe. It steps a horizontal pixel position and a vertical line position through a programmable raster. From that position it decodes the horizontal and vertical blanking and sync levels, and it raises one-cycle markers around vertical blanking: one when blanking begins, one when vertical sync begins, and a frame-start marker that can be pushed back by a programmable number of lines. It also reports a scanline number, a pixel count that restarts at the first visible pixel, and a 32-bit frame count.

Software writes timing values into a shadow set. The live set copies the shadow set only at the moment vertical blanking begins, so the raster never changes in the middle of the visible picture. The vertical sync window sits at fixed places relative to the start of blanking: it rises at horizontal sync of the line after `vblank_on` and falls at horizontal sync two lines after `vblank_on`. The design needs `vblank_on >= 3`, `hblank_on <= hsync_on < hsync_off <= htotal`, and `vblank_on + 1 + frame_delay < vtotal`.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal position runs from 0 to htotal-1. `hblank` is high while the position is at or past hblank_on. `hsync` is high while the position is at least hsync_on and below hsync_off.
- R2: `vblank` rises at horizontal sync start on line vblank_on. It stays high until the last pixel of line vtotal-1. Lines 0 to vblank_on-1 are active.
- R3: `evt_vblank` is high for exactly one cycle, on line vblank_on at horizontal position hsync_on.
- R4: `vsync` rises at hsync_on on line vblank_on+1 and falls at hsync_on on line vblank_on+2. `evt_vsync` pulses for one cycle as it rises.
- R5: `evt_frame` pulses for one cycle at horizontal position hblank_on on line vblank_on+1+D. D is config bits [1:0] (0 to 3).
- R6: Writes go to a shadow set at addresses 0 htotal, 1 hblank_on, 2 hsync_on, 3 hsync_off, 4 vtotal, 5 vblank_on and 6 config. The live set takes the shadow set at the cycle of `evt_vblank`. A write made in that same cycle waits for the next vertical blanking.
- R7: With config bit 2 clear, `frame_count` goes up by one in the cycle after `evt_vblank`.
- R8: With config bit 2 set, `frame_count` goes up by one as the raster enters line 0, position 0, and it does not change at `evt_vblank`.
- R9: `pixel_count` reads 0 at line 0, position 0 and goes up by one every clock after that.
- R10: At or past hsync_on on line v, the scanline reports (v+1) mod vtotal. Before hsync_on it reports v.
- R11: With config bit 3 set, the reported scanline is 2 less than in R10, modulo vtotal.
- R12: After reset, both timing sets hold the parameter defaults, the raster is at line 0, position 0, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow register write strobe |
| wr_addr | input | 3 | Shadow register select |
| wr_data | input | TW (12) | Write value; config uses bits [3:0] |
| hblank | output | 1 | Horizontal blanking level |
| hsync | output | 1 | Horizontal sync level |
| vblank | output | 1 | Vertical blanking level |
| vsync | output | 1 | Vertical sync level |
| evt_vblank | output | 1 | Start-of-vertical-blanking pulse |
| evt_frame | output | 1 | Delayed frame-start pulse |
| evt_vsync | output | 1 | Start-of-vertical-sync pulse |
| scanline | output | TW (12) | Reported scanline number |
| pixel_count | output | CNT_W (32) | Pixels since the first visible pixel |
| frame_count | output | CNT_W (32) | Frame counter |

## Verification
The levels, the three pulses and the scanline are decoded directly from the position registers. They are therefore due in the same cycle as the raster position that defines them. The pixel count, the frame count and the live timing set are registers. Each shows the effect of an event in the cycle after that event. The bench counts clock advances since reset, predicts the exact advance at which each pulse and each counter value is due, and samples between clock edges at that advance. Pulses are matched one by one against a queue of predicted events.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
    localparam int unsigned TW = 12;
    localparam int unsigned AW = 3;

    typedef enum logic [AW-1:0] {
        SEL_HTOTAL    = 3'd0,
        SEL_HBLANK    = 3'd1,
        SEL_HSYNC_ON  = 3'd2,
        SEL_HSYNC_OFF = 3'd3,
        SEL_VTOTAL    = 3'd4,
        SEL_VBLANK    = 3'd5,
        SEL_CONFIG    = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic       sl_shift;   // bit 3: report scanline two lines back
        logic       fc_late;    // bit 2: count frames at first visible pixel
        logic [1:0] fs_extra;   // bits 1:0: extra frame-start lines
    } cfg_t;

    localparam int unsigned CFG_W = $bits(cfg_t);

    typedef struct packed {
        logic [TW-1:0] htotal;
        logic [TW-1:0] hblank_on;
        logic [TW-1:0] hsync_on;
        logic [TW-1:0] hsync_off;
        logic [TW-1:0] vtotal;
        logic [TW-1:0] vblank_on;
        cfg_t          cfg;
    } timing_t;

    function automatic logic [TW-1:0] inc_mod(input logic [TW-1:0] v,
                                              input logic [TW-1:0] total);
        return (v >= total - TW'(1)) ? '0 : v + TW'(1);
    endfunction

    function automatic logic [TW-1:0] sub2_mod(input logic [TW-1:0] v,
                                               input logic [TW-1:0] total);
        return (v >= TW'(2)) ? v - TW'(2) : v + total - TW'(2);
    endfunction
endpackage

// File: rtl/rtg_regs.sv
`timescale 1ns/1ps
module rtg_regs
    import rtg_pkg::*;
#(
    parameter timing_t RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic          latch,
    output timing_t       live
);
    timing_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RESET_VAL;
            live   <= RESET_VAL;
        end else begin
            if (latch)
                live <= shadow;
            if (wr_en) begin
                case (reg_sel_e'(wr_addr))
                    SEL_HTOTAL:    shadow.htotal    <= wr_data;
                    SEL_HBLANK:    shadow.hblank_on <= wr_data;
                    SEL_HSYNC_ON:  shadow.hsync_on  <= wr_data;
                    SEL_HSYNC_OFF: shadow.hsync_off <= wr_data;
                    SEL_VTOTAL:    shadow.vtotal    <= wr_data;
                    SEL_VBLANK:    shadow.vblank_on <= wr_data;
                    SEL_CONFIG:    shadow.cfg       <= cfg_t'(wr_data[CFG_W-1:0]);
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtg_raster.sv
`timescale 1ns/1ps
module rtg_raster
    import rtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] htotal,
    input  logic [TW-1:0] vtotal,
    output logic [TW-1:0] hpos,
    output logic [TW-1:0] vpos,
    output logic          frame_wrap
);
    logic line_end;

    assign line_end   = hpos >= htotal - TW'(1);
    assign frame_wrap = line_end && (vpos >= vtotal - TW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hpos <= '0;
            vpos <= '0;
        end else begin
            hpos <= inc_mod(hpos, htotal);
            if (line_end)
                vpos <= inc_mod(vpos, vtotal);
        end
    end
endmodule

// File: rtl/rtg_decode.sv
`timescale 1ns/1ps
module rtg_decode
    import rtg_pkg::*;
(
    input  timing_t       t,
    input  logic [TW-1:0] hpos,
    input  logic [TW-1:0] vpos,
    output logic          hblank,
    output logic          hsync,
    output logic          vblank,
    output logic          vsync,
    output logic          evt_vb,
    output logic          evt_fs,
    output logic          evt_vs,
    output logic [TW-1:0] scanline
);
    logic [TW-1:0] vs_line, vs_end_line, fs_line, raw_line;
    logic          past_hs, at_hs;
    logic          unused_fields;

    assign unused_fields = ^{t.htotal, t.cfg.fc_late};

    assign vs_line     = t.vblank_on + TW'(1);
    assign vs_end_line = t.vblank_on + TW'(2);
    assign fs_line     = t.vblank_on + TW'(1) + TW'(t.cfg.fs_extra);

    assign past_hs = hpos >= t.hsync_on;
    assign at_hs   = hpos == t.hsync_on;

    always_comb begin
        hblank = hpos >= t.hblank_on;
        hsync  = past_hs && (hpos < t.hsync_off);
        vblank = (vpos > t.vblank_on) || ((vpos == t.vblank_on) && past_hs);
        vsync  = ((vpos == vs_line) && past_hs) ||
                 ((vpos == vs_end_line) && !past_hs);
        evt_vb = at_hs && (vpos == t.vblank_on);
        evt_vs = at_hs && (vpos == vs_line);
        evt_fs = (hpos == t.hblank_on) && (vpos == fs_line);
        raw_line = past_hs ? inc_mod(vpos, t.vtotal) : vpos;
        scanline = t.cfg.sl_shift ? sub2_mod(raw_line, t.vtotal) : raw_line;
    end
endmodule

// File: rtl/rtg_counters.sv
`timescale 1ns/1ps
module rtg_counters #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_vb,
    input  logic          frame_wrap,
    input  logic          fc_late,
    output logic [CW-1:0] pixels,
    output logic [CW-1:0] frames
);
    logic frame_tick;

    assign frame_tick = fc_late ? frame_wrap : evt_vb;

    always_ff @(posedge clk) begin
        if (rst) begin
            pixels <= '0;
            frames <= '0;
        end else begin
            pixels <= frame_wrap ? '0 : pixels + CW'(1);
            if (frame_tick)
                frames <= frames + CW'(1);
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int unsigned H_TOTAL    = 20,
    parameter int unsigned H_BLANK    = 14,
    parameter int unsigned H_SYNC_ON  = 16,
    parameter int unsigned H_SYNC_OFF = 18,
    parameter int unsigned V_TOTAL    = 10,
    parameter int unsigned V_BLANK    = 6,
    parameter int unsigned FS_EXTRA   = 0,
    parameter int unsigned CNT_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [TW-1:0]    wr_data,
    output logic             hblank,
    output logic             hsync,
    output logic             vblank,
    output logic             vsync,
    output logic             evt_vblank,
    output logic             evt_frame,
    output logic             evt_vsync,
    output logic [TW-1:0]    scanline,
    output logic [CNT_W-1:0] pixel_count,
    output logic [CNT_W-1:0] frame_count
);
    localparam timing_t RESET_T = '{
        htotal:    TW'(H_TOTAL),
        hblank_on: TW'(H_BLANK),
        hsync_on:  TW'(H_SYNC_ON),
        hsync_off: TW'(H_SYNC_OFF),
        vtotal:    TW'(V_TOTAL),
        vblank_on: TW'(V_BLANK),
        cfg:       '{sl_shift: 1'b0, fc_late: 1'b0, fs_extra: 2'(FS_EXTRA)}
    };

    timing_t       live;
    logic [TW-1:0] hpos, vpos;
    logic          frame_wrap;

    rtg_regs #(.RESET_VAL(RESET_T)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .latch(evt_vblank), .live(live)
    );

    rtg_raster u_raster (
        .clk(clk), .rst(rst), .htotal(live.htotal), .vtotal(live.vtotal),
        .hpos(hpos), .vpos(vpos), .frame_wrap(frame_wrap)
    );

    rtg_decode u_decode (
        .t(live), .hpos(hpos), .vpos(vpos),
        .hblank(hblank), .hsync(hsync), .vblank(vblank), .vsync(vsync),
        .evt_vb(evt_vblank), .evt_fs(evt_frame), .evt_vs(evt_vsync),
        .scanline(scanline)
    );

    rtg_counters #(.CW(CNT_W)) u_counters (
        .clk(clk), .rst(rst), .evt_vb(evt_vblank), .frame_wrap(frame_wrap),
        .fc_late(live.cfg.fc_late), .pixels(pixel_count), .frames(frame_count)
    );
endmodule

// File: rtl/rtg_checker.sv
`timescale 1ns/1ps
module rtg_checker #(
    parameter int unsigned CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          hblank,
    input logic          hsync,
    input logic          vblank,
    input logic          vsync,
    input logic          evt_vblank,
    input logic          evt_frame,
    input logic          evt_vsync,
    input logic [CW-1:0] pixel_count,
    input logic [CW-1:0] frame_count
);
    assert_hsync_in_blank_R1: assert property (@(posedge clk) disable iff (rst)
        hsync |-> hblank);

    assert_vb_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        evt_vblank |=> !evt_vblank);

    assert_vb_at_hsync_R3: assert property (@(posedge clk) disable iff (rst)
        evt_vblank |-> $rose(hsync) && $rose(vblank));   // also R2

    assert_vs_edge_R4: assert property (@(posedge clk) disable iff (rst)
        evt_vsync |-> $rose(vsync));

    assert_fs_edge_R5: assert property (@(posedge clk) disable iff (rst)
        evt_frame |-> $rose(hblank) && vblank);

    assert_frame_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_count) |-> frame_count == $past(frame_count) + 1'b1);  // also R8

    assert_pixel_step_R9: assert property (@(posedge clk) disable iff (rst)
        (pixel_count != '0) |-> pixel_count == $past(pixel_count) + 1'b1);
endmodule

bind raster_timing_gen rtg_checker #(.CW(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .hblank(hblank), .hsync(hsync),
    .vblank(vblank), .vsync(vsync), .evt_vblank(evt_vblank),
    .evt_frame(evt_frame), .evt_vsync(evt_vsync),
    .pixel_count(pixel_count), .frame_count(frame_count)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb;
    import rtg_pkg::*;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [TW-1:0] wr_data = '0;
    logic hblank, hsync, vblank, vsync, evt_vblank, evt_frame, evt_vsync;
    logic [TW-1:0] scanline;
    logic [CW-1:0] pixel_count, frame_count;

    raster_timing_gen u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hblank(hblank), .hsync(hsync), .vblank(vblank), .vsync(vsync),
        .evt_vblank(evt_vblank), .evt_frame(evt_frame), .evt_vsync(evt_vsync),
        .scanline(scanline), .pixel_count(pixel_count), .frame_count(frame_count)
    );

    always #2.5 clk = ~clk;

    typedef struct { int kind; int at; } ev_t;
    ev_t sb[$];
    ev_t got;

    int pos = 0, cycles = 0, n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        pos    <= rst ? 0 : pos + 1;
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at pos %0d: actual %0d expected %0d",
                     req, what, pos, act, exp);
        end
    endtask

    function automatic string req_of(input int kind);
        case (kind)
            0: return "R3";
            1: return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic push_ev(input int kind, input int at);
        sb.push_back('{kind, at});
    endtask

    // Monitor: pops one predicted event for every pulse the design produces.
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int k = 0; k < 3; k++) begin
                logic pulse;
                pulse = (k == 0) ? evt_vblank : (k == 1) ? evt_frame : evt_vsync;
                if (pulse) begin
                    if (sb.size() == 0) begin
                        check(req_of(k), "unexpected event", 64'(pos), 64'(-1));
                    end else begin
                        got = sb.pop_front();
                        check(req_of(got.kind), "event kind*10000+position",
                              64'(k * 10000 + pos), 64'(got.kind * 10000 + got.at));
                    end
                end
            end
        end
    end

    task automatic wait_pos(input int target);
        while (pos < target) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        sb.delete();
        rst = 1'b0;
    endtask

    task automatic wr(input int at, input int addr, input int data);
        wait_pos(at);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = TW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 5000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        // ---------- Phase A: default raster H=20 V=10 vblank_on=6 ----------
        do_reset();
        check("R12", "hblank", 64'(hblank), 0);
        check("R12", "vblank", 64'(vblank), 0);
        check("R12", "vsync", 64'(vsync), 0);
        check("R12", "scanline", 64'(scanline), 0);
        check("R12", "pixel_count", pixel_count, 0);
        check("R12", "frame_count", frame_count, 0);
        push_ev(0, 136); push_ev(1, 154); push_ev(2, 156);
        push_ev(0, 336); push_ev(1, 364); push_ev(2, 366);
        wait_pos(13);  check("R1", "hblank before", 64'(hblank), 0);
        wait_pos(14);  check("R1", "hblank on", 64'(hblank), 1);
        wait_pos(15);  check("R1", "hsync before", 64'(hsync), 0);
        wait_pos(16);  check("R1", "hsync on", 64'(hsync), 1);
        wait_pos(18);  check("R1", "hsync off", 64'(hsync), 0);
        wait_pos(135);
        check("R2", "vblank before hsync", 64'(vblank), 0);
        check("R10", "scanline before hsync", 64'(scanline), 6);
        check("R7", "frame_count before", frame_count, 0);
        wait_pos(136);
        check("R2", "vblank at hsync", 64'(vblank), 1);
        check("R10", "scanline at hsync", 64'(scanline), 7);
        // R6: write htotal=30 in the latch cycle; must wait one frame
        wr_en = 1'b1; wr_addr = AW'(SEL_HTOTAL); wr_data = TW'(30);
        @(negedge clk);
        wr_en = 1'b0;
        check("R7", "frame_count after vblank", frame_count, 1);
        wait_pos(154); check("R9", "pixel_count at frame start", pixel_count, 154);
        wait_pos(155); check("R4", "vsync before", 64'(vsync), 0);
        wait_pos(156); check("R4", "vsync on", 64'(vsync), 1);
        wait_pos(175); check("R4", "vsync held", 64'(vsync), 1);
        wait_pos(176); check("R4", "vsync off", 64'(vsync), 0);
        wait_pos(196); check("R10", "scanline wrap", 64'(scanline), 0);
        wait_pos(199); check("R2", "vblank last pixel", 64'(vblank), 1);
        wait_pos(200);
        check("R2", "vblank cleared at line 0", 64'(vblank), 0);
        check("R9", "pixel_count restart", pixel_count, 0);
        wait_pos(337); check("R7", "frame_count second frame", frame_count, 2);
        wait_pos(343); check("R6", "new htotal live after latch", 64'(hblank), 1);
        wait_pos(380); check("R3", "all predicted events seen", 64'(sb.size()), 0);

        // ---------- Phase B: reprogram to H=24 V=12 vblank_on=5, config 0xF ----------
        do_reset();
        push_ev(0, 136); push_ev(1, 204);
        push_ev(0, 398); push_ev(2, 422); push_ev(1, 492);
        push_ev(0, 686); push_ev(2, 710); push_ev(1, 780);
        wr(1, 0, 24); wr(2, 1, 12); wr(3, 2, 14); wr(4, 3, 16);
        wr(5, 4, 12); wr(6, 5, 5);  wr(7, 6, 15);
        wait_pos(36);  check("R6", "shadow write not yet live", 64'(hsync), 1);
        wait_pos(137); check("R7", "count at vblank in early mode", frame_count, 1);
        wait_pos(263); check("R8", "frame_count before line 0", frame_count, 1);
        wait_pos(264);
        check("R8", "frame_count at first pixel", frame_count, 2);
        check("R9", "pixel_count restart", pixel_count, 0);
        wait_pos(278); check("R6", "new hsync_on live", 64'(hsync), 1);
        wait_pos(280); check("R6", "new hsync_off live", 64'(hsync), 0);
        wait_pos(397); check("R11", "shifted scanline before hsync", 64'(scanline), 3);
        wait_pos(398); check("R11", "shifted scanline at hsync", 64'(scanline), 4);
        wait_pos(399); check("R8", "no count at vblank in late mode", frame_count, 2);
        wait_pos(492); check("R5", "pixel_count at delayed frame start", pixel_count, 228);
        wait_pos(552);
        check("R11", "shifted scanline wraps", 64'(scanline), 10);
        check("R8", "frame_count third frame", frame_count, 3);
        wait_pos(800); check("R5", "all predicted events seen", 64'(sb.size()), 0);
        finish_run();
    end
endmodule